// File: doc/BRIEF.md
# Half-Duplex Serial Transceiver with Attention Phase

This block sends and receives bytes over one shared open-drain wire. A single sequencer serves both directions. It advances only on an internal tick that runs at four times the bit rate. The tick comes from a compare-match divider whose reload value is derived from the clock frequency and the baud rate. With the default 8 MHz clock and 19200 baud, a tick is 104 clock cycles and a bit is 416 cycles.

Before each transmitted byte, the block pulls the line low for four bit times as an attention phase. It then sends a low start bit, eight data bits with the least significant bit first, and a released (high) stop bit.

On the receive side, an idle block that sees the line low waits for the line to be released. Only then does it hunt for a start bit. It samples each data bit and the stop bit on the third tick (index 2 of 0..3) counted from start-bit detection. A good stop bit delivers the byte. A low stop bit raises a framing-error strobe instead.

Top module: `hd_attn_uart`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the block to idle with `line_oe` low, `tx_busy` low, `rx_valid` and `rx_frame_err` low, and `rx_data` equal to 0.
- R2: When `tx_busy` is low, a one-cycle `tx_req` is accepted at that clock edge and `tx_busy` is high from the following cycle. `tx_busy` stays high for exactly 14 bit times (5824 cycles at the defaults) after the accepting edge and is low from that edge on.
- R3: The tick period is CLK_HZ/(4*BAUD) cycles, so the reload value is that quotient minus one (103 at 8 MHz and 19200 baud). The divider restarts when a transmit is accepted, so the first data bit begins exactly 5*416 = 2080 cycles after the accepting edge.
- R4: Once accepted, `line_oe` (1 = pull the line low) is high for 16 ticks of attention and then for 4 ticks of start bit. Next come 8 data bits of 4 ticks each, least significant bit first, with `line_oe` = NOT data bit. The stop bit follows with `line_oe` low for 4 ticks.
- R5: A `tx_req` that arrives while `tx_busy` is high is ignored: the frame in progress keeps the byte latched at acceptance, and no second frame follows it.
- R6: A receive runs in this order: the line is seen low in idle, then released, then a low start bit arrives. The receiver then samples 8 data bits LSB first and a high stop bit. `rx_data` then takes the byte, and `rx_valid` pulses for one cycle as the block returns to idle. `rx_data` changes at no other time.
- R7: A stop bit sampled low gives a one-cycle `rx_frame_err` pulse with no `rx_valid`, and `rx_data` keeps its previous value.
- R8: `tx_busy` is high in every state other than idle, including reception. A `tx_req` during reception does not start a transmit.
- R9: `line_oe` is low in idle and in all receive states; it is only asserted while transmitting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | Level of the shared wire (asynchronous, synchronized inside) |
| line_oe | output | 1 | 1 pulls the shared wire low; 0 releases it |
| tx_data | input | DATA_BITS | Byte to transmit, captured on acceptance |
| tx_req | input | 1 | Transmit request, one cycle, honoured only when not busy |
| tx_busy | output | 1 | Sequencer is not idle |
| rx_data | output | DATA_BITS | Last byte received with a good stop bit |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` was just updated |
| rx_frame_err | output | 1 | One-cycle strobe: stop bit sampled low |

## Verification
The hardest case to reach is a request that arrives mid-frame. It must leave both the frame on the wire and the byte latched for it untouched. The bench therefore pulses `tx_req` with the inverted byte several hundred cycles into a transmit's attention phase. It then checks every bit on the wire against the original byte. A second such request is injected during a received data bit. The bench confirms that the line is never driven and that the byte still arrives. A framing error needs a peer that holds the wire low through the stop bit. The bench models that peer as a wired-AND with the block's own output.

// File: rtl/hd_attn_uart.sv
module hd_attn_uart #(
  parameter int unsigned CLK_HZ    = 8_000_000,
  parameter int unsigned BAUD      = 19_200,
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned ATTN_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 line_in,
  output logic                 line_oe,
  input  logic [DATA_BITS-1:0] tx_data,
  input  logic                 tx_req,
  output logic                 tx_busy,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 rx_frame_err
);

  localparam int unsigned TPB        = 4;
  localparam int unsigned RELOAD     = CLK_HZ / (TPB * BAUD) - 1;
  localparam int unsigned DIV_W      = (RELOAD > 0) ? $clog2(RELOAD + 1) : 1;
  localparam int unsigned ATTN_TICKS = ATTN_BITS * TPB;
  localparam int unsigned SUB_W      = $clog2(ATTN_TICKS);
  localparam int unsigned BIT_W      = $clog2(DATA_BITS);
  localparam int unsigned SAMPLE_IX  = TPB / 2;

  typedef enum logic [3:0] {
    S_IDLE, S_RX_ATTN, S_RX_START, S_RX_DATA, S_RX_STOP,
    S_TX_ATTN, S_TX_START, S_TX_DATA, S_TX_STOP
  } state_t;

  state_t               st;
  logic [DIV_W-1:0]     div;
  logic [SUB_W-1:0]     sub;
  logic [BIT_W-1:0]     bitn;
  logic [DATA_BITS-1:0] sh;
  logic [1:0]           sync;

  wire line_s    = sync[1];
  wire tick      = (div == DIV_W'(RELOAD));
  wire accept    = (st == S_IDLE) && tx_req;
  wire sub_end   = (sub == SUB_W'(TPB - 1));
  wire attn_end  = (sub == SUB_W'(ATTN_TICKS - 1));
  wire at_sample = (sub == SUB_W'(SAMPLE_IX));
  wire last_bit  = (bitn == BIT_W'(DATA_BITS - 1));
  wire [SUB_W-1:0] sub_inc = sub + 1'b1;

  assign tx_busy = (st != S_IDLE);
  assign line_oe = (st == S_TX_ATTN) || (st == S_TX_START) || ((st == S_TX_DATA) && !sh[0]);

  always_ff @(posedge clk) begin
    if (rst || accept || tick) div <= '0;
    else                       div <= div + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], line_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      sub          <= '0;
      bitn         <= '0;
      sh           <= '0;
      rx_data      <= '0;
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
    end else begin
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
      if (accept) begin
        st   <= S_TX_ATTN;
        sub  <= '0;
        bitn <= '0;
        sh   <= tx_data;
      end else if (tick) begin
        case (st)
          S_IDLE:
            if (!line_s) st <= S_RX_ATTN;
          S_RX_ATTN:
            if (line_s) begin
              st  <= S_RX_START;
              sub <= '0;
            end
          S_RX_START:
            if (sub != '0) begin
              if (sub_end) begin
                st   <= S_RX_DATA;
                sub  <= '0;
                bitn <= '0;
              end else sub <= sub_inc;
            end else if (!line_s) sub <= SUB_W'(1);
          S_RX_DATA: begin
            if (at_sample) sh <= {line_s, sh[DATA_BITS-1:1]};
            if (sub_end) begin
              sub <= '0;
              if (last_bit) st <= S_RX_STOP;
              else          bitn <= bitn + 1'b1;
            end else sub <= sub_inc;
          end
          S_RX_STOP:
            if (at_sample) begin
              st  <= S_IDLE;
              sub <= '0;
              if (line_s) begin
                rx_data  <= sh;
                rx_valid <= 1'b1;
              end else rx_frame_err <= 1'b1;
            end else sub <= sub_inc;
          S_TX_ATTN:
            if (attn_end) begin
              st  <= S_TX_START;
              sub <= '0;
            end else sub <= sub_inc;
          S_TX_START:
            if (sub_end) begin
              st   <= S_TX_DATA;
              sub  <= '0;
              bitn <= '0;
            end else sub <= sub_inc;
          S_TX_DATA:
            if (sub_end) begin
              sub <= '0;
              sh  <= sh >> 1;
              if (last_bit) st <= S_TX_STOP;
              else          bitn <= bitn + 1'b1;
            end else sub <= sub_inc;
          S_TX_STOP:
            if (sub_end) begin
              st  <= S_IDLE;
              sub <= '0;
            end else sub <= sub_inc;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/hd_attn_uart_chk.sv
module hd_attn_uart_chk #(
  parameter int unsigned DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 line_oe,
  input logic                 tx_req,
  input logic                 tx_busy,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 rx_valid,
  input logic                 rx_frame_err
);

  AST_OE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    line_oe |-> tx_busy); // R9

  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !tx_busy) |=> tx_busy); // R2

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R6

  AST_RXDATA_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_data) |-> rx_valid); // R6

  AST_STROBE_AT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (rx_valid || rx_frame_err) |-> !tx_busy); // R6

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_frame_err |=> !rx_frame_err); // R7

  AST_ERR_EXCLUDES_VALID: assert property (@(posedge clk) disable iff (rst)
    !(rx_frame_err && rx_valid)); // R7

endmodule

bind hd_attn_uart hd_attn_uart_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst(rst), .line_oe(line_oe), .tx_req(tx_req), .tx_busy(tx_busy),
  .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
);

// File: tb/tb_hd_attn_uart.sv
`timescale 1ns/1ps
module tb_hd_attn_uart;
  localparam int CLK_HZ = 8_000_000;
  localparam int BAUD   = 19_200;
  localparam int BITC   = (CLK_HZ / (4 * BAUD)) * 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       peer = 1'b0;
  logic       line_in, line_oe, tx_req = 1'b0, tx_busy, rx_valid, rx_frame_err;
  logic [7:0] tx_data = 8'h00, rx_data;

  int checks = 0, fails = 0;
  int vcnt = 0, ecnt = 0, oe_cnt = 0;
  logic [7:0] cap = 8'h00;

  assign line_in = !(line_oe || peer);

  hd_attn_uart #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) dut (
    .clk(clk), .rst(rst), .line_in(line_in), .line_oe(line_oe),
    .tx_data(tx_data), .tx_req(tx_req), .tx_busy(tx_busy),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin vcnt++; cap = rx_data; end
      if (rx_frame_err) ecnt++;
      if (line_oe) oe_cnt++;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; peer = 1'b0; tx_req = 1'b0;
    hold(3);
    rst = 1'b0;
    chk(!line_oe, "R1 line_oe", line_oe, 0);
    chk(!tx_busy, "R1 tx_busy", tx_busy, 0);
    chk(!rx_valid && !rx_frame_err, "R1 strobes", {rx_valid, rx_frame_err}, 0);
    chk(rx_data == 8'h00, "R1 rx_data", rx_data, 0);
  endtask

  task automatic tx_frame(input logic [7:0] d, input bit poke);
    logic exp;
    int k;
    string rq;
    rq = poke ? "R4/R5 wire" : "R4 wire";
    chk(!tx_busy, "R2 idle before request", tx_busy, 0);
    tx_data = d; tx_req = 1'b1;
    hold(1);
    tx_req = 1'b0;
    chk(tx_busy, "R2 busy after accept", tx_busy, 1);
    for (int n = 1; n <= 14 * BITC; n++) begin
      hold(1);
      if (poke && n == 500) begin tx_req = 1'b1; tx_data = ~d; end
      if (poke && n == 501) tx_req = 1'b0;
      if (n % BITC == BITC / 2) begin
        k = n / BITC;
        if (k < 5)       exp = 1'b1;
        else if (k < 13) exp = ~d[k-5];
        else             exp = 1'b0;
        chk(line_oe == exp, rq, line_oe, exp);
      end
      if (n == 5 * BITC - 1) chk(line_oe == 1'b1, "R3 start bit end", line_oe, 1);
      if (n == 5 * BITC)     chk(line_oe == ~d[0], "R3 first data edge", line_oe, ~d[0]);
      if (n == 14 * BITC - 1) chk(tx_busy, "R2 busy before frame end", tx_busy, 1);
      if (n == 14 * BITC)     chk(!tx_busy, "R2 idle at frame end", tx_busy, 0);
    end
    tx_data = 8'h00;
    hold(BITC);
    chk(!tx_busy && !line_oe, "R5 no second frame", {tx_busy, line_oe}, 0);
  endtask

  task automatic rx_frame(input logic [7:0] d, input bit good, input int gap, input bit poke);
    int v0, e0, o0;
    logic [7:0] d0;
    v0 = vcnt; e0 = ecnt; o0 = oe_cnt; d0 = rx_data;
    peer = 1'b1;
    hold(4 * BITC);
    chk(tx_busy, "R8 busy during attention", tx_busy, 1);
    peer = 1'b0;
    hold(gap);
    peer = 1'b1;
    hold(BITC);
    for (int i = 0; i < 8; i++) begin
      peer = ~d[i];
      if (poke && i == 3) begin
        hold(10);
        chk(tx_busy, "R8 busy mid-reception", tx_busy, 1);
        tx_data = 8'h00; tx_req = 1'b1;
        hold(1);
        tx_req = 1'b0;
        hold(BITC - 11);
      end else hold(BITC);
    end
    peer = !good;
    hold(BITC);
    peer = 1'b0;
    hold(BITC);
    chk(oe_cnt == o0, "R9 line never driven in receive", oe_cnt - o0, 0);
    if (good) begin
      chk(vcnt == v0 + 1, "R6 one valid strobe", vcnt - v0, 1);
      chk(cap == d, "R6 received byte", cap, d);
      chk(rx_data == d, "R6 rx_data holds", rx_data, d);
      chk(ecnt == e0, "R6 no framing error", ecnt - e0, 0);
      chk(!tx_busy, "R6 back to idle", tx_busy, 0);
    end else begin
      chk(ecnt == e0 + 1, "R7 framing error strobe", ecnt - e0, 1);
      chk(vcnt == v0, "R7 no valid", vcnt - v0, 0);
      chk(rx_data == d0, "R7 rx_data kept", rx_data, d0);
    end
  endtask

  initial begin
    do_reset();
    tx_frame(8'hA5, 1'b1);
    tx_frame(8'h00, 1'b0);
    tx_frame(8'hFF, 1'b0);
    rx_frame(8'h3C, 1'b1, BITC, 1'b0);
    rx_frame(8'h00, 1'b1, 150, 1'b0);
    rx_frame(8'hFF, 1'b1, 2 * BITC, 1'b1);
    tx_frame(8'h81, 1'b0);
    rx_frame(8'h5A, 1'b1, BITC, 1'b0);
    rx_frame(8'hC3, 1'b0, BITC, 1'b0);
    do_reset();
    rx_frame(8'h96, 1'b1, BITC, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 190_000);
    checks++;
    fails++;
    $display("FAIL watchdog R2 act=%0h exp=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule